// File: doc/BRIEF.md
# Chainable SPI Register Slave

This block is an SPI slave holding three 8-bit registers: two wiper setting registers and one control register. Several copies can be strung together: the serial output of one copy feeds the serial input of the next, while chip select and serial clock go to every copy in parallel. The whole chain then acts as one long shift path, 16 bits per copy. The host shifts in one two-byte frame per copy, with the frame for the copy farthest from the host going first. Each frame holds an instruction byte and then a data byte.

Nothing is decoded while bits are moving. When chip select goes high, each copy looks at the frame that is left in its own 16-bit shift register and acts on it. Every copy in the chain therefore acts at the same moment. A read is split over two chip-select frames. The first frame posts the request. During the next frame the copy shifts out a header byte and then the register contents, while the host shifts in no-operation frames.

The pins are sampled by the block's system clock through synchronizers. The serial clock must therefore be well below the system clock rate. A safe figure is at least four system clocks per serial clock phase.

Top module: `dcs_chain_slave`

## Requirements
- R1: After reset, wiper 0 reads 8'h80, wiper 1 reads 8'h80 and the control register reads 8'h40, and the serial output is 0.
- R2: The instruction byte is {opcode[2:0], addr[4:0]}. Opcode 3'b010 writes the data byte to the addressed register. Wiper 0 sits at address 5'b00000, wiper 1 at 5'b00001 and the control register at 5'b10000. A register changes only when chip select rises.
- R3: Opcode 3'b001 posts a read. In the next chip-select frame the copy shifts out {3'b111, addr} and then the register contents. Data goes MSB first in SPI mode 0: input is sampled on the rising serial clock edge, and the output changes on the falling edge or when chip select falls.
- R4: A bit on the serial input appears on the serial output 16 serial clocks later. When chip select rises, each copy in a chain decodes the last 16 bits it received. So the host shifts the frame for the far copy first.
- R5: If chip select rises after a number of serial clocks that is zero or not a multiple of 16, the frame is dropped and no register changes.
- R6: A write to any address other than the three above is ignored. A read of such an address replies with the header {3'b111, addr} and data 8'h00.
- R7: When chip select falls, the shift register loads the pending read reply if there is one, and all zeros if there is none. A reply is sent only once.
- R8: Opcode 3'b000 (no operation) and the opcodes not defined in R2 and R3 change nothing and post no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_sdi | input | 1 | Serial data in, from the host or the previous copy |
| spi_sdo | output | 1 | Serial data out, to the next copy or the host |

## Verification
The bench drives two copies wired as a chain and compares every bit returned to the host with a bit-level model of two 16-bit shift paths. The bench checks the following cases:
- Frame order. A copy that decoded the first frame instead of the last one would put each write into the wrong copy.
- Commit on chip-select rise. A design that decoded while bits were shifting would change the registers early.
- Frame length. Transfers of 20 bits and of zero clocks are sent. A copy that did not check the length would apply a stale or misaligned instruction.
- Unused addresses and undefined opcodes. These would corrupt a real register or return data that is not zero.
- Reply handling. A reply that was not cleared after it was sent would show up again in the next no-operation frame.
- Header content. The bench checks the 3'b111 header and the echoed address byte by byte.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

    localparam int OP_W    = 3;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int INSTR_W = OP_W + ADDR_W;
    localparam int FRAME_W = INSTR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);

    localparam logic [OP_W-1:0] OP_NOP   = 3'b000;
    localparam logic [OP_W-1:0] OP_READ  = 3'b001;
    localparam logic [OP_W-1:0] OP_WRITE = 3'b010;
    localparam logic [OP_W-1:0] REPLY_TAG = 3'b111;

    localparam logic [ADDR_W-1:0] ADDR_WIPER0 = 5'b00000;
    localparam logic [ADDR_W-1:0] ADDR_WIPER1 = 5'b00001;
    localparam logic [ADDR_W-1:0] ADDR_CTRL   = 5'b10000;

    localparam logic [DATA_W-1:0] WIPER_RST = 8'h80;
    localparam logic [DATA_W-1:0] CTRL_RST  = 8'h40;

    typedef logic [FRAME_W-1:0] frame_t;

    typedef struct packed {
        logic [DATA_W-1:0] wiper0;
        logic [DATA_W-1:0] wiper1;
        logic [DATA_W-1:0] ctrl;
    } regs_t;

    // fields of a frame as it is left in the shift register
    function automatic logic [OP_W-1:0] frame_op(input frame_t f);
        return f[FRAME_W-1 -: OP_W];
    endfunction

    function automatic logic [ADDR_W-1:0] frame_addr(input frame_t f);
        return f[DATA_W +: ADDR_W];
    endfunction

    function automatic logic [DATA_W-1:0] frame_data(input frame_t f);
        return f[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/dcs_edge_sync.sv
module dcs_edge_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);
    // STAGES synchronizing flops plus one history flop for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = pipe_q;
        pipe_d[0] = din;
        for (int s = 1; s < DEPTH; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {DEPTH{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_edge
        assign level[b] = pipe_q[STAGES-1][b];
        assign rise[b]  =  pipe_q[STAGES-1][b] & ~pipe_q[STAGES][b];
        assign fall[b]  = ~pipe_q[STAGES-1][b] &  pipe_q[STAGES][b];
    end

endmodule

// File: rtl/dcs_shifter.sv
module dcs_shifter
    import dcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sel,         // chip select asserted (synchronized level)
    input  logic   sel_start,   // chip select just fell
    input  logic   sck_rise,
    input  logic   sck_fall,
    input  logic   sdi,
    input  logic   load_valid,
    input  frame_t load_word,
    output frame_t shift_word,
    output logic   frame_ok,
    output logic   sdo
);

    typedef struct packed {
        frame_t           sr;
        logic [CNT_W-1:0] cnt;
        logic             any;
        logic             sdo;
    } shift_state_t;

    shift_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sel_start) begin
            st_d.sr  = load_valid ? load_word : '0;
            st_d.cnt = '0;
            st_d.any = 1'b0;
            st_d.sdo = load_valid ? load_word[FRAME_W-1] : 1'b0;
        end else if (sel) begin
            if (sck_rise) begin
                st_d.sr  = {st_q.sr[FRAME_W-2:0], sdi};
                st_d.cnt = (st_q.cnt == CNT_W'(FRAME_W-1)) ? '0 : st_q.cnt + 1'b1;
                st_d.any = 1'b1;
            end
            if (sck_fall) begin
                st_d.sdo = st_q.sr[FRAME_W-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign shift_word = st_q.sr;
    assign frame_ok   = st_q.any && (st_q.cnt == '0);
    assign sdo        = st_q.sdo;

endmodule

// File: rtl/dcs_regfile.sv
module dcs_regfile
    import dcs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   commit,      // chip select rose after a whole number of frames
    input  frame_t cmd,
    input  logic   consume,     // chip select fell: pending reply is taken
    output regs_t  regs,
    output logic   pend_valid,
    output frame_t pend_word
);

    typedef struct packed {
        regs_t  regs;
        logic   pv;
        frame_t pw;
    } rf_state_t;

    rf_state_t st_d, st_q;

    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] rdata;

    always_comb begin
        op    = frame_op(cmd);
        addr  = frame_addr(cmd);
        wdata = frame_data(cmd);
        unique case (addr)
            ADDR_WIPER0: rdata = st_q.regs.wiper0;
            ADDR_WIPER1: rdata = st_q.regs.wiper1;
            ADDR_CTRL:   rdata = st_q.regs.ctrl;
            default:     rdata = '0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (consume) begin
            st_d.pv = 1'b0;
        end
        if (commit) begin
            unique case (op)
                OP_WRITE: begin
                    unique case (addr)
                        ADDR_WIPER0: st_d.regs.wiper0 = wdata;
                        ADDR_WIPER1: st_d.regs.wiper1 = wdata;
                        ADDR_CTRL:   st_d.regs.ctrl   = wdata;
                        default:     ;
                    endcase
                end
                OP_READ: begin
                    st_d.pv = 1'b1;
                    st_d.pw = {REPLY_TAG, addr, rdata};
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.regs.wiper0 <= WIPER_RST;
            st_q.regs.wiper1 <= WIPER_RST;
            st_q.regs.ctrl   <= CTRL_RST;
            st_q.pv          <= 1'b0;
            st_q.pw          <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs       = st_q.regs;
    assign pend_valid = st_q.pv;
    assign pend_word  = st_q.pw;

endmodule

// File: rtl/dcs_chain_slave.sv
module dcs_chain_slave
    import dcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_sdi,
    output logic spi_sdo
);

    localparam int PIN_W = 3;
    localparam int IDX_CS  = 2;
    localparam int IDX_SCK = 1;
    localparam int IDX_SDI = 0;

    logic [PIN_W-1:0] pin_lvl, pin_rise, pin_fall;

    dcs_edge_sync #(
        .WIDTH  (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({spi_cs_n, spi_sck, spi_sdi}),
        .level(pin_lvl),
        .rise (pin_rise),
        .fall (pin_fall)
    );

    logic cs_fall, cs_rise, sel, sck_rise, sck_fall, sdi_s;

    assign sel      = ~pin_lvl[IDX_CS];
    assign cs_fall  = pin_fall[IDX_CS];
    assign cs_rise  = pin_rise[IDX_CS];
    assign sck_rise = pin_rise[IDX_SCK];
    assign sck_fall = pin_fall[IDX_SCK];
    assign sdi_s    = pin_lvl[IDX_SDI];

    frame_t shift_word, pend_word;
    logic   frame_ok, pend_valid, commit;
    regs_t  regs;

    assign commit = cs_rise & frame_ok;

    dcs_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel       (sel),
        .sel_start (cs_fall),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .sdi       (sdi_s),
        .load_valid(pend_valid),
        .load_word (pend_word),
        .shift_word(shift_word),
        .frame_ok  (frame_ok),
        .sdo       (spi_sdo)
    );

    dcs_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .cmd       (shift_word),
        .consume   (cs_fall),
        .regs      (regs),
        .pend_valid(pend_valid),
        .pend_word (pend_word)
    );

endmodule

// File: rtl/dcs_chain_slave_chk.sv
module dcs_chain_slave_chk
    import dcs_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   cs_rise,
    input logic   cs_fall,
    input logic   sck_rise,
    input logic   sck_fall,
    input logic   frame_ok,
    input logic   pend_valid,
    input frame_t pend_word,
    input frame_t shift_word,
    input regs_t  regs,
    input logic   spi_sdo
);

    AST_REG_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (regs != $past(regs)) |-> $past(cs_rise && frame_ok)); // R2

    AST_DROP_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_rise && !frame_ok) |-> (regs == $past(regs) && !pend_valid)); // R5

    AST_REPLY_HEADER: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> (pend_word[FRAME_W-1 -: OP_W] == REPLY_TAG)); // R3

    AST_SDO_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sdo != $past(spi_sdo)) |-> $past(sck_fall || cs_fall)); // R3

    AST_SHIFT_ON_SCK: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_word != $past(shift_word)) |-> $past(sck_rise || cs_fall)); // R4

    AST_LOAD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_fall && !pend_valid) |-> (shift_word == '0)); // R7

    AST_REPLY_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_fall) |-> !pend_valid); // R7

endmodule

bind dcs_chain_slave dcs_chain_slave_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_rise   (cs_rise),
    .cs_fall   (cs_fall),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .frame_ok  (frame_ok),
    .pend_valid(pend_valid),
    .pend_word (pend_word),
    .shift_word(shift_word),
    .regs      (regs),
    .spi_sdo   (spi_sdo)
);

// File: tb/sim_dcs_chain_slave.sv
module sim_dcs_chain_slave;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_CLKS  = 6;
    localparam int WATCHDOG   = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic link, miso;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // u0 is nearest the host, u1 drives the line back to the host
    dcs_chain_slave u0 (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n),
                        .spi_sck(sck), .spi_sdi(mosi), .spi_sdo(link));
    dcs_chain_slave u1 (.clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n),
                        .spi_sck(sck), .spi_sdi(link), .spi_sdo(miso));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---- requirement model: [dev][0]=wiper0 [1]=wiper1 [2]=ctrl
    logic [7:0]  m_reg [2][3];
    logic        m_pv  [2];
    logic [15:0] m_pw  [2];

    task automatic m_reset();
        for (int d = 0; d < 2; d++) begin
            m_reg[d][0] = 8'h80;
            m_reg[d][1] = 8'h80;
            m_reg[d][2] = 8'h40;
            m_pv[d] = 1'b0;
            m_pw[d] = 16'h0;
        end
    endtask

    function automatic int m_idx(input logic [4:0] a);
        if (a == 5'b00000) return 0;
        if (a == 5'b00001) return 1;
        if (a == 5'b10000) return 2;
        return -1;
    endfunction

    task automatic m_exec(input int d, input logic [15:0] w);
        logic [2:0] op;
        logic [4:0] a;
        int i;
        op = w[15:13];
        a  = w[12:8];
        i  = m_idx(a);
        if (op == 3'b010 && i >= 0) m_reg[d][i] = w[7:0];
        else if (op == 3'b001) begin
            m_pv[d] = 1'b1;
            m_pw[d] = {3'b111, a, (i >= 0) ? m_reg[d][i] : 8'h00};
        end
    endtask

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    // n bits, bits[n-1] first; compares host receive stream with model
    task automatic spi_xfer(input string tag, input int n, input logic [63:0] bits);
        logic [15:0] s0, s1;
        logic [63:0] got, exp;
        s0 = m_pv[0] ? m_pw[0] : 16'h0;
        s1 = m_pv[1] ? m_pw[1] : 16'h0;
        m_pv[0] = 1'b0;
        m_pv[1] = 1'b0;
        got = '0;
        exp = '0;
        cs_n = 1'b0;
        wait_clks(HALF_CLKS);
        for (int i = 0; i < n; i++) begin
            mosi = bits[n-1-i];
            wait_clks(HALF_CLKS);
            got = {got[62:0], miso};
            exp = {exp[62:0], s1[15]};
            s1 = {s1[14:0], s0[15]};
            s0 = {s0[14:0], bits[n-1-i]};
            sck = 1'b1;
            wait_clks(HALF_CLKS);
            sck = 1'b0;
        end
        wait_clks(HALF_CLKS);
        cs_n = 1'b1;
        wait_clks(8);
        if (n > 0 && (n % 16) == 0) begin
            m_exec(0, s0);
            m_exec(1, s1);
        end
        check(tag, got, exp);
    endtask

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] bits;   // far-copy frame in [31:16], near-copy frame in [15:0]
    } vec_t;

    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        '{"R1 ", 32'h2000_2000},   // post reads of wiper 0
        '{"R1 ", 32'h2100_2100},   // wiper 0 replies out, post wiper 1 reads
        '{"R1 ", 32'h3000_3000},   // wiper 1 replies out, post ctrl reads
        '{"R1 ", 32'h0000_0000},   // ctrl replies 8'h40
        '{"R2 ", 32'h4011_4022},   // wiper 0 writes, far copy first
        '{"R2 ", 32'h4133_4144},   // wiper 1 writes
        '{"R2 ", 32'h5055_5066},   // ctrl writes
        '{"R3 ", 32'h2000_2100},   // mixed reads
        '{"R3 ", 32'h3000_3000},   // header plus data of both replies
        '{"R7 ", 32'h0000_0000},   // ctrl replies
        '{"R7 ", 32'h0000_0000},   // no reply left: zeros
        '{"R6 ", 32'h4A77_2A00},   // far: unused write, near: unused read
        '{"R6 ", 32'h2A00_0000},   // near reply EA00, far unused read
        '{"R6 ", 32'h0000_0000},   // far reply EA00
        '{"R4 ", 32'h2000_2100},   // far wiper 0 still 8'h11
        '{"R4 ", 32'h0000_0000}
    };

    task automatic do_reset();
        rst_n = 1'b0;
        cs_n = 1'b1;
        sck = 1'b0;
        mosi = 1'b0;
        wait_clks(5);
        rst_n = 1'b1;
        wait_clks(5);
        m_reset();
    endtask

    initial begin
        do_reset();
        check("R1 idle sdo", {63'h0, miso}, 64'h0);
        check("R1 idle link", {63'h0, link}, 64'h0);

        for (int v = 0; v < NVEC; v++) begin
            spi_xfer(string'(VECS[v].tag), 32, {32'h0, VECS[v].bits});
        end

        // R5: 20-bit transfer carrying a write, must be dropped
        spi_xfer("R5 short frame", 20, {44'h0, 4'h0, 16'h4099});
        spi_xfer("R5 readback post", 32, 64'h2000_2000);
        spi_xfer("R5 readback", 32, 64'h0);
        check("R5 near wiper0 kept", 64'(m_reg[0][0]), 64'h22);

        // R5: chip select pulse with no clocks
        spi_xfer("R5 post read", 32, 64'h3000_3000);
        spi_xfer("R5 zero clocks", 0, 64'h0);
        spi_xfer("R5 reply consumed by empty frame", 32, 64'h0);

        // R8: undefined opcodes 3'b110 and 3'b111 change nothing
        spi_xfer("R8 odd opcodes", 32, 64'hC0AA_E0BB);
        spi_xfer("R8 readback post", 32, 64'h2000_2000);
        spi_xfer("R8 readback", 32, 64'h0);

        // R4: 48 bits, first frame passes out of the chain entirely
        spi_xfer("R4 long chain", 48, {16'h0, 16'h40DD, 16'h4101, 16'h4102});
        spi_xfer("R4 readback post", 32, 64'h2100_2100);
        spi_xfer("R4 readback", 32, 64'h0);
        check("R4 far wiper1", 64'(m_reg[1][1]), 64'h01);

        // R3: explicit reply layout from the near copy with a literal value
        spi_xfer("R3 post ctrl read", 32, 64'h0000_3000);
        spi_xfer("R3 ctrl reply", 32, 64'h0);

        // R1: reset mid-run restores defaults
        spi_xfer("R1 write before reset", 32, 64'h4055_4066);
        do_reset();
        spi_xfer("R1 post reads", 32, 64'h2000_3000);
        spi_xfer("R1 defaults", 32, 64'h0);

        // R2: near-copy write then literal readback of the wiper
        spi_xfer("R2 write near", 32, 64'h0000_40A5);
        spi_xfer("R2 post read", 32, 64'h0000_2000);
        spi_xfer("R2 readback", 32, 64'h0);
        check("R2 model wiper0", 64'(m_reg[0][0]), 64'hA5);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule